// File: doc/BRIEF.md
# MESI snooping tag directory

This block holds the tags and per-line MESI coherency states for a physically addressed, 4-way set-associative, write-back cache. With the default parameters it covers 128 sets of 32-byte lines, which is 16 KB of data. The data arrays and the bus protocol sit outside the block.

The directory has two lookup paths that work in the same cycle. The processor port reads, allocates and rewrites lines. The snoop port checks addresses seen on the bus and applies the coherency transition for the snooped operation. When a snoop hits a Modified line, the port flags an address retry and starts a push-out of that line. The processor port stays stalled until the push completes. If a snoop state change and a processor access fall on the same set in one cycle, the snoop wins and the processor request must be presented again.

Lookups are combinational within the cycle. All array updates take effect on the next rising clock edge.

Top module: `mesi_snoop_dir`

## Requirements
- R1: After reset, every line is Invalid, every replacement tree is zero, and no push is pending. Every lookup misses.
- R2: A processor lookup hits when a way of the indexed set holds the address tag in a non-Invalid state. It reports that way and its state. A miss reports state Invalid (code 0). State codes are I=0, S=1, E=2, M=3.
- R3: A fill (cpu_op_i=1) writes the tag and cpu_state_i into the lowest-numbered Invalid way of the set, when the set has one.
- R4: When a set has no Invalid way, a fill replaces the way named by a 3-bit pseudo-LRU tree. Bit 0 set means the victim is in ways 2/3. Bit 1 set means way 1 rather than way 0. Bit 2 set means way 3 rather than way 2. Every lookup hit, state write or fill points the bits on that way's path away from it.
- R5: A snooped read (snp_kill_i=0) that hits an Exclusive or Shared line reports hit and state, and leaves the line Shared. A snoop miss changes nothing.
- R6: A snooped write or read-with-intent-to-modify (snp_kill_i=1) that hits a non-Modified line makes it Invalid.
- R7: A snoop that hits a Modified line raises snp_retry_o without changing the state. If no push is pending, it also raises snp_push_o. The next cycle shows push_pend_o with the line's set, way and tag.
- R8: While a push is pending, cpu_ready_o is low and processor requests change nothing. Snoops to other lines are still serviced.
- R9: push_done_i during a pending push clears it. The line becomes Shared for a snooped read and Invalid for a kill.
- R10: A snoop that hits a Modified line while a push is already pending gets a retry but starts no second push.
- R11: When a snoop changes a line's state in the set that a processor request addresses, cpu_ready_o is low and the processor update is dropped. Requests to other sets proceed in the same cycle.
- R12: A state write (cpu_op_i=2) that hits stores cpu_state_i into the hit way. On a miss it has no effect. Codes 0 and 3 are plain lookups.
- R13: For every processor address, the block reports the victim way of the set together with that way's current tag and state, so a dirty line can be written back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | Processor request valid |
| cpu_op_i | input | 2 | 0/3 lookup, 1 fill, 2 state write |
| cpu_addr_i | input | ADDR_W | Processor physical address |
| cpu_state_i | input | 2 | State to write on fill or state write |
| cpu_ready_o | output | 1 | Request accepted this cycle |
| cpu_hit_o | output | 1 | Processor lookup hit |
| cpu_way_o | output | WAY_W | Hit way |
| cpu_state_o | output | 2 | State of hit line, 0 on miss |
| cpu_vic_way_o | output | WAY_W | Way a fill would use |
| cpu_vic_tag_o | output | TAG_W | Tag currently in the victim way |
| cpu_vic_state_o | output | 2 | State currently in the victim way |
| snp_valid_i | input | 1 | Snoop valid |
| snp_kill_i | input | 1 | 1 for write or read-with-intent-to-modify, 0 for read |
| snp_addr_i | input | ADDR_W | Snooped address |
| snp_hit_o | output | 1 | Snoop hit |
| snp_state_o | output | 2 | State of snooped line before update |
| snp_retry_o | output | 1 | Address retry needed |
| snp_push_o | output | 1 | New push-out started |
| push_done_i | input | 1 | Pending push-out finished |
| push_pend_o | output | 1 | Push-out pending |
| push_set_o | output | IDX_W | Set of pending line |
| push_way_o | output | WAY_W | Way of pending line |
| push_tag_o | output | TAG_W | Tag of pending line |

## Verification
The bench builds the block with 16-bit addresses and 8 sets of 4 ways, which leaves 8-bit tags. At that size every set can be filled, overflowed into pseudo-LRU replacement, rewritten and snooped. A bench model computes every output in every cycle. The narrow configuration lets a single pass take each set through every MESI transition, a push-out with a stalled processor and a repeated retry, and both same-set and cross-set collisions between the two ports.

// File: rtl/mesi_dir_pkg.sv
package mesi_dir_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } mesi_e;

  typedef enum logic [1:0] {
    OP_LOOK  = 2'd0,
    OP_FILL  = 2'd1,
    OP_SETST = 2'd2,
    OP_LOOK3 = 2'd3
  } cpu_op_e;
endpackage

// File: rtl/mesi_way_match.sv
module mesi_way_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 20,
  parameter int WAY_W = 2
) (
  input  logic [WAYS-1:0][TAG_W-1:0] tags_i,
  input  logic [WAYS-1:0][1:0]       st_i,
  input  logic [TAG_W-1:0]           tag_i,
  output logic                       hit_o,
  output logic [WAY_W-1:0]           way_o,
  output logic [1:0]                 st_o
);
  import mesi_dir_pkg::*;

  logic [WAYS-1:0] match;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = (st_i[w] != ST_I) && (tags_i[w] == tag_i);
  end

  always_comb begin
    hit_o = 1'b0;
    way_o = '0;
    st_o  = ST_I;
    for (int w = 0; w < WAYS; w++) begin
      if (match[w]) begin
        hit_o = 1'b1;
        way_o = WAY_W'(w);
        st_o  = st_i[w];
      end
    end
  end
endmodule

// File: rtl/mesi_victim_pick.sv
module mesi_victim_pick #(
  parameter int WAYS  = 4,
  parameter int WAY_W = 2,
  parameter int LRU_W = WAYS - 1
) (
  input  logic [WAYS-1:0][1:0] st_i,
  input  logic [LRU_W-1:0]     lru_i,
  output logic [WAY_W-1:0]     way_o
);
  import mesi_dir_pkg::*;

  logic [WAYS-1:0] tree_sel;
  logic [WAY_W-1:0] tree_way;

  // way w is the tree victim when every node on its path points toward it
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [WAY_W-1:0] on_path;
    for (genvar l = 0; l < WAY_W; l++) begin : g_lvl
      localparam int   NODE = (1 << l) - 1 + (w >> (WAY_W - l));
      localparam logic DIR  = ((w >> (WAY_W - 1 - l)) & 1) != 0;
      assign on_path[l] = (lru_i[NODE] == DIR);
    end
    assign tree_sel[w] = &on_path;
  end

  always_comb begin
    tree_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (tree_sel[w]) tree_way = WAY_W'(w);
    end
    way_o = tree_way;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (st_i[w] == ST_I) way_o = WAY_W'(w);
    end
  end
endmodule

// File: rtl/mesi_plru_next.sv
module mesi_plru_next #(
  parameter int WAYS  = 4,
  parameter int WAY_W = 2,
  parameter int LRU_W = WAYS - 1
) (
  input  logic [LRU_W-1:0] lru_i,
  input  logic [WAY_W-1:0] way_i,
  input  logic             en_i,
  output logic [LRU_W-1:0] lru_o
);
  for (genvar l = 0; l < WAY_W; l++) begin : g_lvl
    for (genvar k = 0; k < (1 << l); k++) begin : g_node
      localparam int NODE = (1 << l) - 1 + k;
      localparam logic [WAY_W-1:0] PFX = WAY_W'(k);
      logic on_path;
      assign on_path     = en_i && ((way_i >> (WAY_W - l)) == PFX);
      assign lru_o[NODE] = on_path ? ~way_i[WAY_W-1-l] : lru_i[NODE];
    end
  end
endmodule

// File: rtl/mesi_push_ctrl.sv
module mesi_push_ctrl #(
  parameter int IDX_W = 7,
  parameter int WAY_W = 2,
  parameter int TAG_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             done_i,
  input  logic [IDX_W-1:0] set_i,
  input  logic [WAY_W-1:0] way_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic             kill_i,
  output logic             pend_o,
  output logic [IDX_W-1:0] set_o,
  output logic [WAY_W-1:0] way_o,
  output logic [TAG_W-1:0] tag_o,
  output logic             kill_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o <= 1'b0;
      set_o  <= '0;
      way_o  <= '0;
      tag_o  <= '0;
      kill_o <= 1'b0;
    end else if (start_i) begin
      pend_o <= 1'b1;
      set_o  <= set_i;
      way_o  <= way_i;
      tag_o  <= tag_i;
      kill_o <= kill_i;
    end else if (done_i) begin
      pend_o <= 1'b0;
    end
  end
endmodule

// File: rtl/mesi_snoop_dir.sv
module mesi_snoop_dir #(
  parameter int ADDR_W     = 32,
  parameter int SETS       = 128,
  parameter int WAYS       = 4,
  parameter int LINE_BYTES = 32,
  localparam int OFF_W = $clog2(LINE_BYTES),
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W,
  localparam int LRU_W = WAYS - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic [1:0]        cpu_op_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [1:0]        cpu_state_i,
  output logic              cpu_ready_o,
  output logic              cpu_hit_o,
  output logic [WAY_W-1:0]  cpu_way_o,
  output logic [1:0]        cpu_state_o,
  output logic [WAY_W-1:0]  cpu_vic_way_o,
  output logic [TAG_W-1:0]  cpu_vic_tag_o,
  output logic [1:0]        cpu_vic_state_o,
  input  logic              snp_valid_i,
  input  logic              snp_kill_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  output logic              snp_hit_o,
  output logic [1:0]        snp_state_o,
  output logic              snp_retry_o,
  output logic              snp_push_o,
  input  logic              push_done_i,
  output logic              push_pend_o,
  output logic [IDX_W-1:0]  push_set_o,
  output logic [WAY_W-1:0]  push_way_o,
  output logic [TAG_W-1:0]  push_tag_o
);
  import mesi_dir_pkg::*;

  logic [WAYS-1:0][TAG_W-1:0] tag_q [SETS];
  logic [WAYS-1:0][1:0]       st_q  [SETS];
  logic [LRU_W-1:0]           lru_q [SETS];

  // processor side
  logic [IDX_W-1:0] c_idx;
  logic [TAG_W-1:0] c_tag;
  logic             c_hit;
  logic [WAY_W-1:0] c_way, c_vic, c_upd_way;
  logic [1:0]       c_st;
  logic [LRU_W-1:0] c_lru_nxt;
  logic             c_go, c_fill, c_setst, c_st_wr, c_touch, conflict;

  assign c_idx = cpu_addr_i[OFF_W +: IDX_W];
  assign c_tag = cpu_addr_i[ADDR_W-1 -: TAG_W];

  mesi_way_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_cpu_match (
    .tags_i(tag_q[c_idx]),
    .st_i  (st_q[c_idx]),
    .tag_i (c_tag),
    .hit_o (c_hit),
    .way_o (c_way),
    .st_o  (c_st)
  );

  mesi_victim_pick #(.WAYS(WAYS), .WAY_W(WAY_W), .LRU_W(LRU_W)) u_victim (
    .st_i (st_q[c_idx]),
    .lru_i(lru_q[c_idx]),
    .way_o(c_vic)
  );

  // snoop side
  logic [IDX_W-1:0] s_idx;
  logic [TAG_W-1:0] s_tag;
  logic             s_hit_raw, s_hit, s_mod, s_wr;
  logic [WAY_W-1:0] s_way;
  logic [1:0]       s_st, s_new;

  assign s_idx = snp_addr_i[OFF_W +: IDX_W];
  assign s_tag = snp_addr_i[ADDR_W-1 -: TAG_W];

  mesi_way_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_snp_match (
    .tags_i(tag_q[s_idx]),
    .st_i  (st_q[s_idx]),
    .tag_i (s_tag),
    .hit_o (s_hit_raw),
    .way_o (s_way),
    .st_o  (s_st)
  );

  assign s_hit = snp_valid_i && s_hit_raw;
  assign s_mod = s_hit && (s_st == ST_M);
  assign s_wr  = s_hit && (s_st != ST_M);
  assign s_new = snp_kill_i ? ST_I : ST_S;

  // push-out tracking
  logic             p_kill;
  logic             p_start;

  assign p_start = s_mod && !push_pend_o;

  mesi_push_ctrl #(.IDX_W(IDX_W), .WAY_W(WAY_W), .TAG_W(TAG_W)) u_push (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(p_start),
    .done_i (push_done_i),
    .set_i  (s_idx),
    .way_i  (s_way),
    .tag_i  (s_tag),
    .kill_i (snp_kill_i),
    .pend_o (push_pend_o),
    .set_o  (push_set_o),
    .way_o  (push_way_o),
    .tag_o  (push_tag_o),
    .kill_o (p_kill)
  );

  // arbitration: snoop state write beats processor on the same set
  assign conflict  = cpu_req_i && s_wr && (s_idx == c_idx);
  assign c_go      = cpu_req_i && !push_pend_o && !conflict;
  assign c_fill    = (cpu_op_i == OP_FILL);
  assign c_setst   = (cpu_op_i == OP_SETST);
  assign c_st_wr   = c_go && (c_fill || (c_setst && c_hit));
  assign c_upd_way = c_fill ? c_vic : c_way;
  assign c_touch   = c_go && (c_fill || c_hit);

  mesi_plru_next #(.WAYS(WAYS), .WAY_W(WAY_W), .LRU_W(LRU_W)) u_plru (
    .lru_i(lru_q[c_idx]),
    .way_i(c_upd_way),
    .en_i (c_touch),
    .lru_o(c_lru_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        st_q[s]  <= '0;
        lru_q[s] <= '0;
      end
    end else begin
      if (push_pend_o && push_done_i)
        st_q[push_set_o][push_way_o] <= p_kill ? ST_I : ST_S;
      if (s_wr)
        st_q[s_idx][s_way] <= s_new;
      if (c_st_wr)
        st_q[c_idx][c_upd_way] <= cpu_state_i;
      if (c_touch)
        lru_q[c_idx] <= c_lru_nxt;
    end
  end

  always_ff @(posedge clk_i) begin
    if (c_go && c_fill) tag_q[c_idx][c_vic] <= c_tag;
  end

  logic [WAYS-1:0][TAG_W-1:0] vic_tags;
  logic [WAYS-1:0][1:0]       vic_sts;
  assign vic_tags = tag_q[c_idx];
  assign vic_sts  = st_q[c_idx];

  assign cpu_ready_o     = !push_pend_o && !conflict;
  assign cpu_hit_o       = c_hit;
  assign cpu_way_o       = c_way;
  assign cpu_state_o     = c_st;
  assign cpu_vic_way_o   = c_vic;
  assign cpu_vic_tag_o   = vic_tags[c_vic];
  assign cpu_vic_state_o = vic_sts[c_vic];

  assign snp_hit_o   = s_hit;
  assign snp_state_o = s_hit ? s_st : ST_I;
  assign snp_retry_o = s_mod;
  assign snp_push_o  = p_start;

  logic unused_off;
  assign unused_off = ^{cpu_addr_i[OFF_W-1:0], snp_addr_i[OFF_W-1:0]};
endmodule

// File: rtl/mesi_snoop_dir_chk.sv
module mesi_snoop_dir_chk #(
  parameter int ADDR_W     = 32,
  parameter int SETS       = 128,
  parameter int LINE_BYTES = 32,
  parameter int WAY_W      = 2,
  localparam int OFF_W = $clog2(LINE_BYTES),
  localparam int IDX_W = $clog2(SETS)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cpu_req_i,
  input logic [ADDR_W-1:0] cpu_addr_i,
  input logic              cpu_ready_o,
  input logic              cpu_hit_o,
  input logic [1:0]        cpu_state_o,
  input logic              snp_valid_i,
  input logic [ADDR_W-1:0] snp_addr_i,
  input logic              snp_hit_o,
  input logic [1:0]        snp_state_o,
  input logic              snp_retry_o,
  input logic              snp_push_o,
  input logic              push_done_i,
  input logic              push_pend_o,
  input logic [IDX_W-1:0]  push_set_o,
  input logic [WAY_W-1:0]  push_way_o
);
  logic same_set;
  assign same_set = cpu_addr_i[OFF_W +: IDX_W] == snp_addr_i[OFF_W +: IDX_W];

  assert_miss_inv_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_hit_o |-> cpu_state_o == 2'd0);

  assert_idle_snoop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snp_valid_i |-> !snp_hit_o && !snp_retry_o && !snp_push_o);

  assert_retry_mod_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_hit_o && snp_state_o == 2'd3 |-> snp_retry_o);

  assert_push_arms_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_push_o |=> push_pend_o);

  assert_push_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_pend_o && !push_done_i |=> push_pend_o && $stable(push_set_o) && $stable(push_way_o));

  assert_cpu_stall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_pend_o |-> !cpu_ready_o);

  assert_push_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_pend_o && push_done_i |=> !push_pend_o);

  assert_one_push_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_pend_o |-> !snp_push_o);

  assert_snoop_wins_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_req_i && snp_hit_o && !snp_retry_o && same_set |-> !cpu_ready_o);

  logic unused_chk;
  assign unused_chk = ^{cpu_addr_i[OFF_W-1:0], snp_addr_i[OFF_W-1:0]};
endmodule

bind mesi_snoop_dir mesi_snoop_dir_chk #(
  .ADDR_W(ADDR_W), .SETS(SETS), .LINE_BYTES(LINE_BYTES), .WAY_W(WAY_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cpu_req_i  (cpu_req_i),
  .cpu_addr_i (cpu_addr_i),
  .cpu_ready_o(cpu_ready_o),
  .cpu_hit_o  (cpu_hit_o),
  .cpu_state_o(cpu_state_o),
  .snp_valid_i(snp_valid_i),
  .snp_addr_i (snp_addr_i),
  .snp_hit_o  (snp_hit_o),
  .snp_state_o(snp_state_o),
  .snp_retry_o(snp_retry_o),
  .snp_push_o (snp_push_o),
  .push_done_i(push_done_i),
  .push_pend_o(push_pend_o),
  .push_set_o (push_set_o),
  .push_way_o (push_way_o)
);

// File: tb/mesi_snoop_dir_test.sv
`timescale 1ns/1ps
module mesi_snoop_dir_test;
  localparam int AW = 16, NS = 8, NW = 4, LB = 32;
  localparam int TW = 8, IW = 3, WW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          cpu_req, snp_valid, snp_kill, push_done;
  logic [1:0]    cpu_op, cpu_st;
  logic [AW-1:0] cpu_addr, snp_addr;
  logic          cpu_ready, cpu_hit, snp_hit, snp_retry, snp_push, push_pend;
  logic [WW-1:0] cpu_way, cpu_vic_way, push_way;
  logic [1:0]    cpu_state, cpu_vic_state, snp_state;
  logic [TW-1:0] cpu_vic_tag, push_tag;
  logic [IW-1:0] push_set;

  mesi_snoop_dir #(.ADDR_W(AW), .SETS(NS), .WAYS(NW), .LINE_BYTES(LB)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_i(cpu_req), .cpu_op_i(cpu_op), .cpu_addr_i(cpu_addr), .cpu_state_i(cpu_st),
    .cpu_ready_o(cpu_ready), .cpu_hit_o(cpu_hit), .cpu_way_o(cpu_way), .cpu_state_o(cpu_state),
    .cpu_vic_way_o(cpu_vic_way), .cpu_vic_tag_o(cpu_vic_tag), .cpu_vic_state_o(cpu_vic_state),
    .snp_valid_i(snp_valid), .snp_kill_i(snp_kill), .snp_addr_i(snp_addr),
    .snp_hit_o(snp_hit), .snp_state_o(snp_state), .snp_retry_o(snp_retry), .snp_push_o(snp_push),
    .push_done_i(push_done), .push_pend_o(push_pend), .push_set_o(push_set),
    .push_way_o(push_way), .push_tag_o(push_tag)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // bench model
  logic [TW-1:0] m_tag [NS][NW];
  logic [1:0]    m_st  [NS][NW];
  logic [2:0]    m_lru [NS];
  logic          m_pend, m_pkill;
  logic [IW-1:0] m_pset;
  logic [WW-1:0] m_pway;
  logic [TW-1:0] m_ptag;

  function automatic logic [AW-1:0] mk(input int t, input int s);
    return {t[TW-1:0], s[IW-1:0], 5'(s * 3)};
  endfunction

  task automatic chk(input string tg, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tg, what, act, exp);
    end
  endtask

  task automatic step(input string tg, input logic creq, input logic [1:0] cop,
                      input logic [AW-1:0] ca, input logic [1:0] cs,
                      input logic sv, input logic sk, input logic [AW-1:0] sa, input logic dn);
    int ci, si, eway, evic, sway;
    logic [TW-1:0] ct, stg;
    logic ehit, shit, smod, swr, eready, ego, epush;
    logic [1:0] est, sst;
    logic [2:0] b;
    @(negedge clk);
    cpu_req = creq; cpu_op = cop; cpu_addr = ca; cpu_st = cs;
    snp_valid = sv; snp_kill = sk; snp_addr = sa; push_done = dn;
    #2;
    ci = int'(ca[5 +: IW]); ct = ca[AW-1 -: TW];
    si = int'(sa[5 +: IW]); stg = sa[AW-1 -: TW];
    ehit = 0; eway = 0; est = 0;
    for (int w = 0; w < NW; w++)
      if (m_st[ci][w] != 0 && m_tag[ci][w] == ct) begin ehit = 1; eway = w; est = m_st[ci][w]; end
    b = m_lru[ci];
    evic = !b[0] ? (b[1] ? 1 : 0) : (b[2] ? 3 : 2);
    for (int w = NW - 1; w >= 0; w--) if (m_st[ci][w] == 0) evic = w;
    shit = 0; sway = 0; sst = 0;
    for (int w = 0; w < NW; w++)
      if (sv && m_st[si][w] != 0 && m_tag[si][w] == stg) begin shit = 1; sway = w; sst = m_st[si][w]; end
    smod = shit && sst == 3;
    swr = shit && sst != 3;
    epush = smod && !m_pend;
    eready = !m_pend && !(creq && swr && ci == si);
    ego = creq && eready;

    chk(tg, "cpu_ready", cpu_ready, eready);
    chk(tg, "cpu_hit", cpu_hit, ehit);
    chk(tg, "cpu_state", cpu_state, est);
    if (ehit) chk(tg, "cpu_way", cpu_way, eway);
    chk(tg, "vic_way", cpu_vic_way, evic);
    chk(tg, "vic_state", cpu_vic_state, m_st[ci][evic]);
    if (m_st[ci][evic] != 0) chk(tg, "vic_tag", cpu_vic_tag, m_tag[ci][evic]);
    chk(tg, "snp_hit", snp_hit, shit);
    chk(tg, "snp_state", snp_state, sst);
    chk(tg, "snp_retry", snp_retry, smod);
    chk(tg, "snp_push", snp_push, epush);
    chk(tg, "push_pend", push_pend, m_pend);
    if (m_pend) begin
      chk(tg, "push_set", push_set, m_pset);
      chk(tg, "push_way", push_way, m_pway);
      chk(tg, "push_tag", push_tag, m_ptag);
    end

    // model update for the coming edge
    if (m_pend && dn) begin m_st[m_pset][m_pway] = m_pkill ? 2'd0 : 2'd1; m_pend = 0; end
    if (swr) m_st[si][sway] = sk ? 2'd0 : 2'd1;
    if (epush) begin m_pend = 1; m_pset = IW'(si); m_pway = WW'(sway); m_ptag = stg; m_pkill = sk; end
    if (ego) begin
      int tw;
      logic touch;
      touch = 0; tw = eway;
      if (cop == 2'd1) begin
        m_tag[ci][evic] = ct; m_st[ci][evic] = cs; touch = 1; tw = evic;
      end else if (cop == 2'd2 && ehit) begin
        m_st[ci][eway] = cs; touch = 1;
      end else if (ehit) touch = 1;
      if (touch) begin
        m_lru[ci][0] = ~tw[1];
        if (tw[1] == 0) m_lru[ci][1] = ~tw[0]; else m_lru[ci][2] = ~tw[0];
      end
    end
  endtask

  task automatic cpu(input string tg, input logic [1:0] op, input logic [AW-1:0] a, input logic [1:0] s);
    step(tg, 1, op, a, s, 0, 0, '0, 0);
  endtask

  task automatic snp(input string tg, input logic k, input logic [AW-1:0] a);
    step(tg, 0, 0, '0, 0, 1, k, a, 0);
  endtask

  task automatic push_flow(input int s, input int w, input logic k);
    logic [AW-1:0] a;
    a = mk(int'(m_tag[s][w]), s);
    snp("R7", k, a);
    cpu("R8", 2'd1, mk(200, s), 2'd2);
    step("R8", 1, 2'd0, a, 0, 1, 0, mk(201, (s + 1) % NS), 0);
    snp("R10", 0, a);
    step("R9", 0, 0, '0, 0, 0, 0, '0, 1);
    cpu("R9", 2'd0, a, 0);
    cpu("R8", 2'd0, mk(200, s), 0);
  endtask

  initial begin
    for (int s = 0; s < NS; s++) begin
      m_lru[s] = '0;
      for (int w = 0; w < NW; w++) begin m_tag[s][w] = '0; m_st[s][w] = '0; end
    end
    m_pend = 0; m_pkill = 0; m_pset = '0; m_pway = '0; m_ptag = '0;
    cpu_req = 0; cpu_op = 0; cpu_addr = '0; cpu_st = 0;
    snp_valid = 0; snp_kill = 0; snp_addr = '0; push_done = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    for (int s = 0; s < NS; s++)
      for (int t = 0; t < 4; t++) cpu("R1", 2'd0, mk(t + 1, s), 0);

    for (int s = 0; s < NS; s++)
      for (int w = 0; w < NW; w++) cpu("R3", 2'd1, mk(16 + w, s), 2'((w + s) % 3 + 1));

    for (int s = 0; s < NS; s++) begin
      for (int w = 0; w < NW; w++) cpu("R2", 2'd0, mk(16 + w, s), 0);
      cpu("R2", 2'd3, mk(99, s), 0);
    end

    for (int s = 0; s < NS; s++) begin
      cpu("R4", 2'd1, mk(40, s), 2'd2);
      cpu("R13", 2'd1, mk(41, s), 2'd1);
      cpu("R4", 2'd0, mk(16 + (s % 4), s), 0);
      cpu("R4", 2'd1, mk(42, s), 2'd2);
    end

    for (int s = 0; s < NS; s++) begin
      cpu("R12", 2'd2, mk(int'(m_tag[s][0]), s), 2'd3);
      cpu("R12", 2'd2, mk(150, s), 2'd2);
      cpu("R12", 2'd0, mk(int'(m_tag[s][0]), s), 0);
      cpu("R12", 2'd0, mk(150, s), 0);
    end

    for (int s = 0; s < NS; s++) begin
      for (int w = 0; w < NW; w++) begin
        logic k;
        k = 1'((s + w) % 2);
        if (m_st[s][w] == 2'd3) push_flow(s, w, k);
        else if (k) snp("R6", 1, mk(int'(m_tag[s][w]), s));
        else snp("R5", 0, mk(int'(m_tag[s][w]), s));
      end
      snp("R5", 0, mk(120, s));
    end

    for (int s = 0; s < NS; s++) cpu("R3", 2'd1, mk(60, s), 2'd2);
    for (int s = 0; s < NS; s++)
      step("R11", 1, 2'd0, mk(60, s), 0, 1, 0, mk(60, (s + 1) % NS), 0);
    for (int s = 0; s < NS; s++) begin
      step("R11", 1, 2'd2, mk(60, s), 2'd3, 1, 0, mk(60, s), 0);
      cpu("R11", 2'd0, mk(60, s), 0);
      cpu("R11", 2'd2, mk(60, s), 2'd3);
      cpu("R11", 2'd0, mk(60, s), 0);
    end
    if (m_pend) step("R9", 0, 0, '0, 0, 0, 0, '0, 1);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule